// File: doc/BRIEF.md
# Open-Row DRAM Bank Sequencer

This block accepts one cache-block read at a time and turns it into a legal stream of bank commands for a four-bank DRAM device. Each request carries a flat address, which the block splits into row, bank and column fields. The block remembers which row, if any, is open in every bank. From that record it sorts each access into one of three classes: empty bank, row hit, or row conflict. The class decides the command sequence. Rows are left open after an access, so that a later read to the same row costs only column reads.

A block of 64 bytes is fetched as a burst of eight column reads from the open row. The eight byte-wide chip lanes that come back for each read are joined into one 64-bit beat, so the requester receives eight beats in column order. A free-running timer raises a refresh request. The block serves that request between client reads by closing every open bank and then issuing a refresh command. The command spacing after an activate, after a precharge, from a read to its data, and after a refresh are all parameters.

Top module: `dram_bank_seq`

## Requirements
- R1: The request address `reqAddr` is split with the row in bits [22:11], the bank in bits [10:9] and the column in bits [8:0]. The burst base column is the column with its three low bits cleared. The `cmdBank` field carries the bank on ACTIVATE, READ and PRECHARGE. The `cmdRow` field carries the row on ACTIVATE. The command codes on `cmd` are: 0 for no-op, 1 for ACTIVATE, 2 for READ, 3 for PRECHARGE and 4 for REFRESH.
- R2: When a request targets a bank with no open row, the block issues ACTIVATE of the requested row, followed by the column reads. No PRECHARGE is issued.
- R3: When a request targets the row already open in its bank, the block issues only the column reads. No ACTIVATE and no PRECHARGE is issued.
- R4: When a request targets a bank that holds a different open row, the block issues PRECHARGE of that bank, then ACTIVATE of the new row, then the column reads.
- R5: Every request produces exactly eight READ commands, in consecutive cycles, to columns base+0 through base+7 in ascending order.
- R6: Every request returns exactly eight beats on `beatValid`/`beatData`. Beat k holds the data read at column base+k, and lane i (bits 8i+7:8i of `laneData`) lands in bits 8i+7:8i of the beat.
- R7: A READ follows the ACTIVATE of its bank by at least T_RCD cycles. An ACTIVATE or REFRESH follows the most recent PRECHARGE by at least T_RP cycles. The data of a READ seen in cycle n is sampled from `laneData` in cycle n+T_CL and appears as a beat in cycle n+T_CL+1.
- R8: REFRESH commands follow each other, and the release of reset, by no more than REF_INTERVAL+64 cycles. The default REF_INTERVAL of 390 cycles at 200 MHz covers 4096 rows within 8 ms.
- R9: Before a REFRESH, every open bank is precharged, one bank per cycle, lowest-numbered bank first. After a refresh, every bank is empty, so the next request to any bank is handled as in R2.
- R10: `reqReady` is low from the cycle after a request is accepted until the cycle in which its eighth beat is presented. No command appears on `cmd` outside a request, except the precharges and the refresh of R9.
- R11: After reset, `cmd` is no-op, `beatValid` is low, `reqReady` is high and all banks are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request offered |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqAddr | input | 23 | Flat request address: row, bank, column |
| laneData | input | 64 | Eight 8-bit read lanes from the devices |
| cmd | output | 3 | Command code (0 no-op, 1 activate, 2 read, 3 precharge, 4 refresh) |
| cmdBank | output | 2 | Bank of the current command |
| cmdRow | output | 12 | Row of an activate command |
| cmdCol | output | 9 | Column of a read command |
| beatValid | output | 1 | A read beat is presented |
| beatData | output | 64 | Assembled 64-bit read beat |

## Verification
A stale or corrupt open-row record does not stay hidden. It shows up on the very next access to that bank as a command sequence of the wrong class: a missing PRECHARGE, a surplus ACTIVATE, or a READ to a closed bank. That error is visible on `cmd` within two cycles of the request being accepted. A wrong column counter or beat counter shows up in the same burst. It appears as a column field out of sequence, or as beat data whose column-dependent pattern does not match, one T_CL+1 cycles later. A refresh that skips a bank is caught at the REFRESH command itself, because a bank is still open at that point.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_REF = 3'd4
  } cmd_e;

  // strobes from the sequencing control to the address/data path
  typedef struct packed {
    logic load;     // latch a new request address
    logic colStep;  // a read is issued, advance the burst column
    logic selRef;   // bank field comes from the refresh bank pick
    cmd_e cmd;      // command launched this cycle
  } dbs_stb_t;

endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 8,
  parameter int REF_INTERVAL = 390
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] curBank,
  input  logic [ROW_W-1:0]  curRow,
  input  logic              colLast,
  input  logic              beatLast,
  output dbs_stb_t          stb,
  output logic [BANK_W-1:0] refBank,
  output logic              reqReady
);

  localparam int NB     = 1 << BANK_W;
  localparam int W1     = (T_RFC > T_RCD) ? T_RFC : T_RCD;
  localparam int WMAX   = (W1 > T_RP) ? W1 : T_RP;
  localparam int WAIT_W = $clog2(WMAX + 1);
  localparam int RT_W   = $clog2(REF_INTERVAL);

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_ACTW, S_RDW, S_RD, S_DRAIN, S_REFPRE, S_REFW
  } state_e;

  state_e              state, nState;
  logic [WAIT_W-1:0]   waitCnt, nWait;
  logic                waitLd;
  logic [NB-1:0]       openV, nOpenV;
  logic [ROW_W-1:0]    openRow [NB];
  logic                rowWr;
  logic                refPending, refTaken;
  logic [RT_W-1:0]     refTimer;
  logic                anyOpen;
  logic [BANK_W-1:0]   lowBank;
  logic                waitDone;

  assign waitDone = (waitCnt == '0);
  assign reqReady = (state == S_IDLE) && !refPending;
  assign refBank  = lowBank;

  // lowest-numbered open bank, used by the refresh close-out
  always_comb begin
    anyOpen = 1'b0;
    lowBank = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (openV[b]) begin
        anyOpen = 1'b1;
        lowBank = BANK_W'(b);
      end
    end
  end

  always_comb begin
    nState   = state;
    nOpenV   = openV;
    rowWr    = 1'b0;
    waitLd   = 1'b0;
    nWait    = '0;
    refTaken = 1'b0;
    stb      = '{load: 1'b0, colStep: 1'b0, selRef: 1'b0, cmd: CMD_NOP};
    case (state)
      S_IDLE: begin
        if (refPending) nState = S_REFPRE;
        else if (reqValid) begin
          stb.load = 1'b1;
          nState   = S_DECIDE;
        end
      end
      S_DECIDE: begin
        if (!openV[curBank]) begin
          stb.cmd         = CMD_ACT;
          nOpenV[curBank] = 1'b1;
          rowWr           = 1'b1;
          waitLd          = 1'b1;
          nWait           = WAIT_W'(T_RCD - 1);
          nState          = S_RDW;
        end else if (openRow[curBank] == curRow) begin
          stb.cmd     = CMD_RD;
          stb.colStep = 1'b1;
          nState      = S_RD;
        end else begin
          stb.cmd         = CMD_PRE;
          nOpenV[curBank] = 1'b0;
          waitLd          = 1'b1;
          nWait           = WAIT_W'(T_RP - 1);
          nState          = S_ACTW;
        end
      end
      S_ACTW: begin
        if (waitDone) begin
          stb.cmd         = CMD_ACT;
          nOpenV[curBank] = 1'b1;
          rowWr           = 1'b1;
          waitLd          = 1'b1;
          nWait           = WAIT_W'(T_RCD - 1);
          nState          = S_RDW;
        end
      end
      S_RDW: begin
        if (waitDone) begin
          stb.cmd     = CMD_RD;
          stb.colStep = 1'b1;
          nState      = S_RD;
        end
      end
      S_RD: begin
        stb.cmd     = CMD_RD;
        stb.colStep = 1'b1;
        if (colLast) nState = S_DRAIN;
      end
      S_DRAIN: begin
        if (beatLast) nState = S_IDLE;
      end
      S_REFPRE: begin
        if (anyOpen) begin
          stb.cmd         = CMD_PRE;
          stb.selRef      = 1'b1;
          nOpenV[lowBank] = 1'b0;
          waitLd          = 1'b1;
          nWait           = WAIT_W'(T_RP - 1);
        end else if (waitDone) begin
          stb.cmd  = CMD_REF;
          refTaken = 1'b1;
          waitLd   = 1'b1;
          nWait    = WAIT_W'(T_RFC - 1);
          nState   = S_REFW;
        end
      end
      S_REFW: begin
        if (waitDone) nState = S_IDLE;
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      waitCnt    <= '0;
      openV      <= '0;
      refPending <= 1'b0;
      refTimer   <= '0;
    end else begin
      state <= nState;
      openV <= nOpenV;
      if (waitLd)        waitCnt <= nWait;
      else if (!waitDone) waitCnt <= waitCnt - 1'b1;
      if (refTaken) refPending <= 1'b0;
      if (refTimer == RT_W'(REF_INTERVAL - 1)) begin
        refTimer   <= '0;
        refPending <= 1'b1;
      end else begin
        refTimer <= refTimer + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rowWr) openRow[curBank] <= curRow;
  end

endmodule

// File: rtl/dbs_dp.sv
module dbs_dp
  import dbs_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int BURST  = 8,
  parameter int T_CL   = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ROW_W+BANK_W+COL_W-1:0] reqAddr,
  input  logic [LANES*LANE_W-1:0]       laneData,
  input  dbs_stb_t                      stb,
  input  logic [BANK_W-1:0]             refBank,
  output logic [BANK_W-1:0]             curBank,
  output logic [ROW_W-1:0]              curRow,
  output logic                          colLast,
  output logic                          beatLast,
  output logic [2:0]                    cmd,
  output logic [BANK_W-1:0]             cmdBank,
  output logic [ROW_W-1:0]              cmdRow,
  output logic [COL_W-1:0]              cmdCol,
  output logic                          beatValid,
  output logic [LANES*LANE_W-1:0]       beatData
);

  localparam int IDX_W  = $clog2(BURST);
  localparam int DATA_W = LANES * LANE_W;

  logic [COL_W-IDX_W-1:0] baseHi;
  logic [IDX_W-1:0]       colIdx, beatCnt;
  logic [T_CL-1:0]        rdPipe;
  logic                   rdNow, capture;
  logic [DATA_W-1:0]      assembled;
  cmd_e                   cmdQ;

  // lane i fills bits [8i+7:8i] of the beat
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign assembled[i*LANE_W +: LANE_W] = laneData[i*LANE_W +: LANE_W];
  end

  assign colLast  = (colIdx == IDX_W'(BURST - 1));
  assign rdNow    = (cmdQ == CMD_RD);
  assign capture  = rdPipe[T_CL-1];
  assign beatLast = capture && (beatCnt == IDX_W'(BURST - 1));
  assign cmd      = cmdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBank   <= '0;
      curRow    <= '0;
      baseHi    <= '0;
      colIdx    <= '0;
      cmdQ      <= CMD_NOP;
      cmdBank   <= '0;
      cmdRow    <= '0;
      cmdCol    <= '0;
      rdPipe    <= '0;
      beatCnt   <= '0;
      beatValid <= 1'b0;
      beatData  <= '0;
    end else begin
      if (stb.load) begin
        curRow  <= reqAddr[COL_W+BANK_W +: ROW_W];
        curBank <= reqAddr[COL_W +: BANK_W];
        baseHi  <= reqAddr[COL_W-1:IDX_W];
        colIdx  <= '0;
      end else if (stb.colStep) begin
        colIdx <= colIdx + 1'b1;
      end
      cmdQ    <= stb.cmd;
      cmdBank <= (stb.cmd == CMD_NOP || stb.cmd == CMD_REF) ? '0 :
                 (stb.selRef ? refBank : curBank);
      cmdRow  <= (stb.cmd == CMD_ACT) ? curRow : '0;
      cmdCol  <= (stb.cmd == CMD_RD) ? {baseHi, colIdx} : '0;
      rdPipe  <= T_CL'({rdPipe, rdNow});
      beatValid <= capture;
      if (capture) begin
        beatData <= assembled;
        beatCnt  <= beatCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dbs_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int BANK_W       = 2,
  parameter int COL_W        = 9,
  parameter int LANES        = 8,
  parameter int LANE_W       = 8,
  parameter int BURST        = 8,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_CL         = 3,
  parameter int T_RFC        = 8,
  parameter int REF_INTERVAL = 390
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [ROW_W+BANK_W+COL_W-1:0] reqAddr,
  input  logic [LANES*LANE_W-1:0]       laneData,
  output logic [2:0]                    cmd,
  output logic [BANK_W-1:0]             cmdBank,
  output logic [ROW_W-1:0]              cmdRow,
  output logic [COL_W-1:0]              cmdCol,
  output logic                          beatValid,
  output logic [LANES*LANE_W-1:0]       beatData
);

  dbs_stb_t          stb;
  logic [BANK_W-1:0] refBank, curBank;
  logic [ROW_W-1:0]  curRow;
  logic              colLast, beatLast;

  dbs_ctrl #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .curBank(curBank),
    .curRow(curRow), .colLast(colLast), .beatLast(beatLast), .stb(stb),
    .refBank(refBank), .reqReady(reqReady)
  );

  dbs_dp #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .LANES(LANES),
    .LANE_W(LANE_W), .BURST(BURST), .T_CL(T_CL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .laneData(laneData),
    .stb(stb), .refBank(refBank), .curBank(curBank), .curRow(curRow),
    .colLast(colLast), .beatLast(beatLast), .cmd(cmd), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .beatValid(beatValid),
    .beatData(beatData)
  );

endmodule

// File: rtl/dbs_chk.sv
module dbs_chk
  import dbs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int BURST  = 8,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] cmdBank,
  input logic              beatValid
);

  localparam int NB = 1 << BANK_W;

  logic [NB-1:0] openV;
  logic [7:0]    sinceAct [NB];
  logic [7:0]    sincePre;
  logic [7:0]    outstanding;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openV       <= '0;
      sincePre    <= 8'hff;
      outstanding <= '0;
      for (int b = 0; b < NB; b++) sinceAct[b] <= 8'hff;
    end else begin
      if (cmd == CMD_ACT) openV[cmdBank] <= 1'b1;
      if (cmd == CMD_PRE) openV[cmdBank] <= 1'b0;
      sincePre <= (cmd == CMD_PRE) ? 8'd0 :
                  (sincePre == 8'hff) ? sincePre : sincePre + 8'd1;
      for (int b = 0; b < NB; b++) begin
        if (cmd == CMD_ACT && cmdBank == BANK_W'(b)) sinceAct[b] <= 8'd0;
        else if (sinceAct[b] != 8'hff) sinceAct[b] <= sinceAct[b] + 8'd1;
      end
      if (reqValid && reqReady) outstanding <= 8'(BURST);
      else if (beatValid && outstanding != 0) outstanding <= outstanding - 8'd1;
    end
  end

  assert_act_closed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ACT) |-> !openV[cmdBank]);
  assert_rd_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_RD) |-> openV[cmdBank]);
  assert_pre_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_PRE) |-> openV[cmdBank]);
  assert_beat_owned_R6: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> (outstanding != 0));
  assert_rcd_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_RD) |-> (sinceAct[cmdBank] >= 8'(T_RCD - 1)));
  assert_rp_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ACT || cmd == CMD_REF) |-> (sincePre >= 8'(T_RP - 1)));
  assert_ref_closed_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_REF) |-> (openV == '0));
  assert_ready_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && outstanding != 0) |-> (beatValid && outstanding == 8'd1));

endmodule

bind dram_bank_seq dbs_chk #(
  .BANK_W(BANK_W), .BURST(BURST), .T_RCD(T_RCD), .T_RP(T_RP)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmd(cmd), .cmdBank(cmdBank), .beatValid(beatValid)
);

// File: tb/dram_bank_seq_tb_top.sv
`timescale 1ns/1ps
module dram_bank_seq_tb_top;

  localparam int ROW_W = 12, BANK_W = 2, COL_W = 9, BURST = 8;
  localparam int T_RCD = 3, T_RP = 3, T_CL = 3, REF_INTERVAL = 390;
  localparam int REF_SLACK = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [22:0] reqAddr = '0;
  logic [63:0] laneData = '0;
  logic [2:0]  cmd;
  logic [1:0]  cmdBank;
  logic [11:0] cmdRow;
  logic [8:0]  cmdCol;
  logic        beatValid;
  logic [63:0] beatData;

  always #2.5 clk = ~clk;

  dram_bank_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .laneData(laneData), .cmd(cmd), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .beatValid(beatValid),
    .beatData(beatData)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] beatPat(input int b, input int r, input int c);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = 8'(c * 3 + r * 5 + b * 50 + i * 17);
    return v;
  endfunction

  // reference state
  bit [3:0] mOpen = '0;
  int mRow [4];
  int expCmd [16], expBank [16], expRow [16], expCol [16];
  string expTag [16];
  int expLen = 0, expPtr = 0;
  bit inFlight = 0, readyBad = 0;
  int beatCnt = 0, curB = 0, curR = 0, curBase = 0;
  int cyc = 0, lastAct [4], lastPre = -100, lastRef = 0, prevRd = 0, rdSeen = 0, refCount = 0;
  bit hV [8];
  int hB [8], hR [8], hC [8];

  initial begin
    for (int b = 0; b < 4; b++) begin lastAct[b] = -100; mRow[b] = 0; end
    for (int k = 0; k < 8; k++) hV[k] = 0;
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      cyc++;
      // device model: data of a read appears T_CL cycles later
      for (int k = 7; k > 0; k--) begin
        hV[k] = hV[k-1]; hB[k] = hB[k-1]; hR[k] = hR[k-1]; hC[k] = hC[k-1];
      end
      hV[0] = (cmd == 3'd2); hB[0] = int'(cmdBank); hR[0] = mRow[cmdBank]; hC[0] = int'(cmdCol);
      laneData = hV[T_CL] ? beatPat(hB[T_CL], hR[T_CL], hC[T_CL]) : 64'd0;

      if (inFlight && reqReady && !(beatValid && beatCnt == BURST - 1)) readyBad = 1;

      if (cmd != 3'd0) begin
        if (inFlight) begin
          if (expPtr < expLen) begin
            chk(cmd == 3'(expCmd[expPtr]), {expTag[expPtr], " command"}, 64'(cmd), 64'(expCmd[expPtr]));
            chk(cmdBank == 2'(expBank[expPtr]), "R1 bank field", 64'(cmdBank), 64'(expBank[expPtr]));
            if (expCmd[expPtr] == 1)
              chk(cmdRow == 12'(expRow[expPtr]), "R1 row field", 64'(cmdRow), 64'(expRow[expPtr]));
            if (expCmd[expPtr] == 2)
              chk(cmdCol == 9'(expCol[expPtr]), "R5 column order", 64'(cmdCol), 64'(expCol[expPtr]));
            expPtr++;
          end else begin
            chk(0, "R5 surplus command", 64'(cmd), 64'd0);
          end
          if (cmd == 3'd2) begin
            if (rdSeen > 0) chk(cyc == prevRd + 1, "R5 reads back to back", 64'(cyc), 64'(prevRd + 1));
            rdSeen++; prevRd = cyc;
          end
        end else if (cmd == 3'd3) begin
          chk(mOpen[cmdBank], "R9 refresh precharges an open bank", 64'(mOpen), 64'(cmdBank));
        end else if (cmd == 3'd4) begin
          chk(mOpen == 4'd0, "R9 all banks closed at refresh", 64'(mOpen), 64'd0);
          chk(cyc - lastRef <= REF_INTERVAL + REF_SLACK, "R8 refresh spacing", 64'(cyc - lastRef), 64'(REF_INTERVAL + REF_SLACK));
          lastRef = cyc; refCount++;
        end else begin
          chk(0, "R10 command outside a request", 64'(cmd), 64'd0);
        end
        if (cmd == 3'd2) chk(cyc - lastAct[cmdBank] >= T_RCD, "R7 activate to read", 64'(cyc - lastAct[cmdBank]), 64'(T_RCD));
        if (cmd == 3'd1 || cmd == 3'd4) chk(cyc - lastPre >= T_RP, "R7 precharge gap", 64'(cyc - lastPre), 64'(T_RP));
        if (cmd == 3'd1) begin mOpen[cmdBank] = 1; mRow[cmdBank] = int'(cmdRow); lastAct[cmdBank] = cyc; end
        if (cmd == 3'd3) begin mOpen[cmdBank] = 0; lastPre = cyc; end
      end

      if (beatValid) begin
        if (inFlight && beatCnt < BURST) begin
          chk(beatData == beatPat(curB, curR, curBase + beatCnt), "R6 beat data", beatData, beatPat(curB, curR, curBase + beatCnt));
          beatCnt++;
          if (beatCnt == BURST) begin
            chk(expPtr == expLen, "R5 full command sequence", 64'(expPtr), 64'(expLen));
            chk(!readyBad, "R10 ready low during burst", 64'(readyBad), 64'd0);
            inFlight = 0;
          end
        end else begin
          chk(0, "R6 beat without request", 64'(beatCnt), 64'(BURST));
        end
      end
    end
  end

  task automatic doRead(input int b, input int r, input int c);
    int n;
    string cls;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = {12'(r), 2'(b), 9'(c)};
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    n = 0;
    curB = b; curR = r; curBase = c & ~(BURST - 1);
    if (!mOpen[b]) cls = "R2 empty";
    else if (mRow[b] == r) cls = "R3 hit";
    else cls = "R4 conflict";
    if (mOpen[b] && mRow[b] != r) begin
      expCmd[n] = 3; expBank[n] = b; expRow[n] = 0; expCol[n] = 0; expTag[n] = cls; n++;
    end
    if (!(mOpen[b] && mRow[b] == r)) begin
      expCmd[n] = 1; expBank[n] = b; expRow[n] = r; expCol[n] = 0; expTag[n] = cls; n++;
    end
    for (int k = 0; k < BURST; k++) begin
      expCmd[n] = 2; expBank[n] = b; expRow[n] = 0; expCol[n] = curBase + k; expTag[n] = cls; n++;
    end
    expLen = n; expPtr = 0; beatCnt = 0; readyBad = 0; rdSeen = 0;
    inFlight = 1;
    @(negedge clk);
    reqValid = 1'b0;
    while (inFlight) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmd == 3'd0, "R11 reset command", 64'(cmd), 64'd0);
    chk(!beatValid, "R11 reset beat", 64'(beatValid), 64'd0);
    chk(reqReady, "R11 reset ready", 64'(reqReady), 64'd1);
    // per-bank empty, hit, conflict and hit at top column
    for (int b = 0; b < 4; b++) begin
      doRead(b, 100 + b, 0);
      doRead(b, 100 + b, 13);
      doRead(b, 200 + b, 16);
      doRead(b, 200 + b, 511);
    end
    for (int b = 0; b < 4; b++) doRead(b, 200 + b, 40 + b);
    doRead(0, 4095, 256);
    // idle long enough for refresh to close all banks
    repeat (2 * REF_INTERVAL) @(negedge clk);
    chk(mOpen == 4'd0, "R9 banks empty after refresh", 64'(mOpen), 64'd0);
    chk(refCount > 0, "R8 refresh issued", 64'(refCount), 64'd1);
    doRead(2, 202, 64);
    // mixed sweep over banks, rows and columns
    for (int i = 0; i < 24; i++) doRead(i % 4, ((i / 4) % 3) * 1000 + 7, (i * 21) % 512);
    repeat (20) @(negedge clk);
    chk(cyc - lastRef <= REF_INTERVAL + REF_SLACK, "R8 refresh recent at end", 64'(cyc - lastRef), 64'(REF_INTERVAL + REF_SLACK));
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R10 watchdog actual=%0d expected=<%0d", 150000, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule